// File: doc/BRIEF.md
# Phase-Step FSK Discriminator

This block turns a complex baseband stream into FSK data decisions. The stream comes from one mixer whose frequency sits midway between the two tones. For each accepted sample, the block estimates the sample's angle with a fixed-point arctangent. The arctangent uses a ratio of sums and differences of I and |Q|, which makes it insensitive to the signal's amplitude. The block then subtracts the angle of the sample before it.

Angles are 16-bit two's-complement fractions of a full turn. Because of this, the subtraction wraps on its own whenever the phase passes through half a turn. Each tone advances the phase by a fixed amount on every sample, so the sign of that step separates the two tones. The step itself is also available to downstream logic, for example a slicer with hysteresis.

The arctangent ratio comes from a fully pipelined restoring divider, so one new sample can be accepted on every clock.

Top module: `fsk_phase_disc`

## Requirements
- R1: Angles are in units of 2^-16 turn. With e = 2^(PH_W-3), the angle is computed as follows. For I >= 0 it is e - floor(e*|I-|Q||/(I+|Q|)), with the floor term added instead of subtracted when I-|Q| < 0. For I < 0 it is 3e - floor(e*|I+|Q||/(|Q|-I)), with the floor term added instead of subtracted when I+|Q| < 0. The result is negated when Q < 0, and all arithmetic is modulo 2^16.
- R2: out_diff is the current angle minus the previous angle, modulo 2^16. A step that crosses half a turn therefore appears as a small step, not as a jump of nearly a full turn.
- R3: out_bit is 1 exactly when out_diff, read as a signed value, is greater than zero. Otherwise it is 0.
- R4: After reset, the first valid sample only loads the previous-angle register and produces no out_valid.
- R5: An all-zero sample (I = 0 and Q = 0) is taken as angle 0. It still raises out_valid, but out_diff and out_bit keep their earlier values.
- R6: Every valid sample after the first yields exactly one out_valid pulse. The pulse arrives PH_W clock edges after the edge that sampled the input, in input order, for any spacing of inputs including back-to-back.
- R7: A synchronous reset clears out_valid, out_diff and out_bit to 0.
- R8: Between out_valid pulses, out_diff and out_bit do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_i | input | IN_W | In-phase sample, signed |
| in_q | input | IN_W | Quadrature sample, signed |
| out_valid | output | 1 | Result strobe |
| out_diff | output | PH_W | Wrapped phase step, signed fraction of a turn |
| out_bit | output | 1 | Hard decision, 1 for a positive step |

## Verification
A sample sampled at clock edge n produces its step and decision right after edge n+PH_W. That delay is one input register, PH_W-2 divider stages, one angle register and one step register.

When the driver sends a sample, it stamps the expected item with the cycle number at which the result is due. The monitor samples on the falling edge and requires each out_valid to land exactly on the stamped cycle with the stamped values. On every cycle without out_valid, the monitor also checks that the held outputs are unchanged.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
  typedef struct packed {
    logic zero;   // I and Q both zero
    logic ineg;   // I < 0: use the 3/8-turn base
    logic nneg;   // ratio numerator negative: add the correction term
    logic qneg;   // Q < 0: negate the angle
  } fpd_side_t;
endpackage

// File: rtl/fpd_front.sv
module fpd_front
  import fpd_pkg::*;
#(
  parameter int IN_W = 12,
  parameter int NW   = IN_W + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   v_i,
  input  logic signed [IN_W-1:0] i_i,
  input  logic signed [IN_W-1:0] q_i,
  output logic                   v_o,
  output logic [NW-1:0]          num_o,
  output logic [NW-1:0]          den_o,
  output fpd_side_t              side_o
);
  localparam int EW = IN_W + 2;

  logic signed [EW-1:0] si, sq, aq, nraw, draw, mag;

  always_comb begin
    si = EW'(i_i);
    sq = EW'(q_i);
    aq = (sq < 0) ? -sq : sq;
    if (si >= 0) begin
      nraw = si - aq;
      draw = si + aq;
    end else begin
      nraw = si + aq;
      draw = aq - si;
    end
    mag = (nraw < 0) ? -nraw : nraw;
  end

  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else     v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    num_o       <= mag[NW-1:0];
    den_o       <= draw[NW-1:0];
    side_o.zero <= (i_i == '0) && (q_i == '0);
    side_o.ineg <= i_i[IN_W-1];
    side_o.nneg <= nraw[EW-1];
    side_o.qneg <= q_i[IN_W-1];
  end
endmodule

// File: rtl/fpd_div.sv
module fpd_div
  import fpd_pkg::*;
#(
  parameter int NW = 13,
  parameter int FR = 13,
  parameter int QW = FR + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          v_i,
  input  logic [NW-1:0] num_i,
  input  logic [NW-1:0] den_i,
  input  fpd_side_t     side_i,
  output logic          v_o,
  output logic [QW-1:0] quo_o,
  output fpd_side_t     side_o
);
  localparam int ST = FR + 1;

  logic          vld   [ST];
  logic [NW:0]   rem   [ST];
  logic [NW-1:0] dnr   [ST];
  logic [QW-1:0] quo_r [ST];
  fpd_side_t     sd    [ST];

  for (genvar k = 0; k < ST; k++) begin : g_st
    if (k == 0) begin : g_int
      logic ge;
      assign ge = (num_i >= den_i);
      always_ff @(posedge clk) begin
        if (rst) vld[0] <= 1'b0;
        else     vld[0] <= v_i;
      end
      always_ff @(posedge clk) begin
        rem[0]   <= ge ? {1'b0, num_i - den_i} : {1'b0, num_i};
        dnr[0]   <= den_i;
        quo_r[0] <= QW'(ge);
        sd[0]    <= side_i;
      end
    end else begin : g_frac
      logic [NW:0] t;
      logic        ge;
      assign t  = {rem[k-1][NW-1:0], 1'b0};
      assign ge = (t >= {1'b0, dnr[k-1]});
      always_ff @(posedge clk) begin
        if (rst) vld[k] <= 1'b0;
        else     vld[k] <= vld[k-1];
      end
      always_ff @(posedge clk) begin
        rem[k]   <= ge ? (t - {1'b0, dnr[k-1]}) : t;
        dnr[k]   <= dnr[k-1];
        quo_r[k] <= {quo_r[k-1][QW-2:0], ge};
        sd[k]    <= sd[k-1];
      end
    end
  end

  assign v_o    = vld[ST-1];
  assign quo_o  = quo_r[ST-1];
  assign side_o = sd[ST-1];
endmodule

// File: rtl/fpd_angle.sv
module fpd_angle
  import fpd_pkg::*;
#(
  parameter int PH_W = 16,
  parameter int FR   = PH_W - 3,
  parameter int QW   = FR + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            v_i,
  input  logic [QW-1:0]   term_i,
  input  fpd_side_t       side_i,
  output logic            v_o,
  output logic [PH_W-1:0] ph_o,
  output logic            zero_o
);
  localparam logic [PH_W-1:0] BASE_LO = PH_W'(1 << FR);
  localparam logic [PH_W-1:0] BASE_HI = PH_W'(3 << FR);

  logic [PH_W-1:0] base, t, a, a_s;

  always_comb begin
    base = side_i.ineg ? BASE_HI : BASE_LO;
    t    = PH_W'(term_i);
    a    = side_i.nneg ? (base + t) : (base - t);
    a_s  = side_i.qneg ? (PH_W'(0) - a) : a;
  end

  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else     v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    ph_o   <= side_i.zero ? '0 : a_s;
    zero_o <= side_i.zero;
  end
endmodule

// File: rtl/fpd_step.sv
module fpd_step #(
  parameter int PH_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            v_i,
  input  logic [PH_W-1:0] ph_i,
  input  logic            zero_i,
  output logic            out_valid,
  output logic [PH_W-1:0] out_diff,
  output logic            out_bit
);
  logic            primed;
  logic [PH_W-1:0] prev, dnext;

  assign dnext = ph_i - prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      primed    <= 1'b0;
      prev      <= '0;
      out_valid <= 1'b0;
      out_diff  <= '0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (v_i) begin
        prev   <= ph_i;
        primed <= 1'b1;
        if (primed) begin
          out_valid <= 1'b1;
          if (!zero_i) begin
            out_diff <= dnext;
            out_bit  <= !dnext[PH_W-1] && (|dnext);
          end
        end
      end
    end
  end
endmodule

// File: rtl/fsk_phase_disc.sv
module fsk_phase_disc
  import fpd_pkg::*;
#(
  parameter int IN_W = 12,
  parameter int PH_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic signed [IN_W-1:0] in_i,
  input  logic signed [IN_W-1:0] in_q,
  output logic                   out_valid,
  output logic [PH_W-1:0]        out_diff,
  output logic                   out_bit
);
  localparam int FR = PH_W - 3;
  localparam int QW = FR + 1;
  localparam int NW = IN_W + 1;

  logic            f_v, d_v, a_v, a_zero;
  logic [NW-1:0]   f_num, f_den;
  logic [QW-1:0]   d_quo;
  logic [PH_W-1:0] a_ph;
  fpd_side_t       f_side, d_side;

  fpd_front #(.IN_W(IN_W), .NW(NW)) front_i (
    .clk(clk), .rst(rst), .v_i(in_valid), .i_i(in_i), .q_i(in_q),
    .v_o(f_v), .num_o(f_num), .den_o(f_den), .side_o(f_side)
  );

  fpd_div #(.NW(NW), .FR(FR), .QW(QW)) div_i (
    .clk(clk), .rst(rst), .v_i(f_v), .num_i(f_num), .den_i(f_den),
    .side_i(f_side), .v_o(d_v), .quo_o(d_quo), .side_o(d_side)
  );

  fpd_angle #(.PH_W(PH_W), .FR(FR), .QW(QW)) angle_i (
    .clk(clk), .rst(rst), .v_i(d_v), .term_i(d_quo), .side_i(d_side),
    .v_o(a_v), .ph_o(a_ph), .zero_o(a_zero)
  );

  fpd_step #(.PH_W(PH_W)) step_i (
    .clk(clk), .rst(rst), .v_i(a_v), .ph_i(a_ph), .zero_i(a_zero),
    .out_valid(out_valid), .out_diff(out_diff), .out_bit(out_bit)
  );
endmodule

// File: rtl/fpd_chk.sv
module fpd_chk #(
  parameter int IN_W = 12,
  parameter int PH_W = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic signed [IN_W-1:0] in_i,
  input logic signed [IN_W-1:0] in_q,
  input logic                   out_valid,
  input logic [PH_W-1:0]        out_diff,
  input logic                   out_bit
);
  logic [PH_W:0] hist;
  logic [1:0]    nseen;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist  <= '0;
      nseen <= '0;
    end else begin
      hist <= {hist[PH_W-1:0], in_valid};
      if (hist[PH_W] && nseen != 2'd2) nseen <= nseen + 2'd1;
    end
  end

  assert_quiet_after_reset_R7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_diff == '0 && !out_bit));

  assert_bit_sign_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_bit == ($signed(out_diff) > 0)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_diff) && $stable(out_bit)));

  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> hist[PH_W]);

  assert_first_silent_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (nseen != 2'd0));
endmodule

bind fsk_phase_disc fpd_chk #(.IN_W(IN_W), .PH_W(PH_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
  .out_valid(out_valid), .out_diff(out_diff), .out_bit(out_bit)
);

// File: tb/fsk_phase_disc_tb_top.sv
module fsk_phase_disc_tb_top;
  localparam int IN_W = 12;
  localparam int PH_W = 16;
  localparam int LAT  = PH_W;
  localparam int EI   = 1 << (PH_W - 3);
  localparam int MOD  = 1 << PH_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [IN_W-1:0] in_i = '0;
  logic signed [IN_W-1:0] in_q = '0;
  logic out_valid;
  logic [PH_W-1:0] out_diff;
  logic out_bit;

  always #5 clk = ~clk;

  fsk_phase_disc #(.IN_W(IN_W), .PH_W(PH_W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_diff(out_diff), .out_bit(out_bit)
  );

  typedef struct {
    logic [PH_W-1:0] d;
    logic            b;
    longint          due;
    string           tag;
  } exp_t;

  exp_t   sb[$];
  int     tests = 0, fails = 0;
  longint cyc = 0;
  bit     mon_on = 0, done = 0;
  int     m_prev = 0;
  bit     m_primed = 0;
  logic [PH_W-1:0] m_diff = '0;
  logic   m_bit = 1'b0;
  logic [PH_W-1:0] last_d = '0;
  logic   last_b = 1'b0;
  int     n_out = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int angle_of(int i, int q);
    int aq, num, den, base, mag, term, a;
    aq = (q < 0) ? -q : q;
    if (i >= 0) begin num = i - aq; den = i + aq; base = EI; end
    else        begin num = i + aq; den = aq - i; base = 3 * EI; end
    mag  = (num < 0) ? -num : num;
    term = (mag * EI) / den;
    a    = (num < 0) ? base + term : base - term;
    if (q < 0) a = -a;
    return a & (MOD - 1);
  endfunction

  task automatic send(int i, int q, string tag);
    exp_t e;
    int   ph;
    @(negedge clk);
    in_valid = 1'b1;
    in_i = IN_W'(i);
    in_q = IN_W'(q);
    ph = (i == 0 && q == 0) ? 0 : angle_of(i, q);
    if (m_primed) begin
      if (!(i == 0 && q == 0)) begin
        m_diff = PH_W'((ph - m_prev) & (MOD - 1));
        m_bit  = (m_diff != 0) && !m_diff[PH_W-1];
      end
      e.d = m_diff; e.b = m_bit; e.due = cyc + 1 + LAT; e.tag = tag;
      sb.push_back(e);
    end
    m_primed = 1;
    m_prev   = ph;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares on the falling edge
  always @(negedge clk) begin
    if (mon_on && !rst) begin
      if (out_valid) begin
        n_out++;
        if (sb.size() == 0) begin
          check(0, "R4", "unexpected out_valid", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(cyc == e.due, "R6", {e.tag, " result cycle"}, cyc, e.due);
          check(out_diff == e.d, e.tag, "out_diff", out_diff, e.d);
          check(out_bit == e.b, "R3", {e.tag, " out_bit"}, out_bit, e.b);
        end
        last_d = out_diff;
        last_b = out_bit;
      end else begin
        if (out_diff != last_d || out_bit != last_b)
          check(0, "R8", "outputs changed without out_valid", out_diff, last_d);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    real ang;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7: reset state
    check(out_valid == 1'b0, "R7", "out_valid after reset", out_valid, 0);
    check(out_diff == '0, "R7", "out_diff after reset", out_diff, 0);
    check(out_bit == 1'b0, "R7", "out_bit after reset", out_bit, 0);
    mon_on = 1;

    // R4: first sample only primes the previous-angle register
    send(1000, 0, "R4");
    idle(LAT + 8);
    check(n_out == 0, "R4", "outputs after first sample", n_out, 0);

    // R1: axis and octant points, spaced out
    send(0, 1000, "R1");     idle(3);
    send(-1000, 0, "R1");    idle(1);
    send(0, -1000, "R1");
    send(1000, 0, "R1");
    send(700, 700, "R1");    idle(5);
    send(-500, 300, "R1");
    send(300, -900, "R1");
    send(-2048, -2048, "R1");
    send(2047, -2048, "R1");
    send(-1, 1, "R1");
    idle(LAT + 4);

    // R2: steps across the half-turn boundary in both directions
    for (int k = 0; k < 12; k++) begin
      ang = 0.42 + 0.03 * k;
      send($rtoi(1500.0 * $cos(6.283185307 * ang)), $rtoi(1500.0 * $sin(6.283185307 * ang)), "R2");
    end
    for (int k = 0; k < 12; k++) begin
      ang = 0.58 - 0.03 * k;
      send($rtoi(1500.0 * $cos(6.283185307 * ang)), $rtoi(1500.0 * $sin(6.283185307 * ang)), "R2");
    end

    // R3: tones at +0.1 and -0.1 cycle per sample, back-to-back
    ang = 0.0;
    for (int k = 0; k < 20; k++) begin
      ang = ang + 0.1;
      send($rtoi(1800.0 * $cos(6.283185307 * ang)), $rtoi(1800.0 * $sin(6.283185307 * ang)), "R3");
    end
    for (int k = 0; k < 20; k++) begin
      ang = ang - 0.1;
      send($rtoi(900.0 * $cos(6.283185307 * ang)), $rtoi(900.0 * $sin(6.283185307 * ang)), "R3");
    end

    // R5: zero samples hold the outputs and count as angle 0
    send(0, 0, "R5");
    send(0, 0, "R5");
    send(0, 800, "R5");
    send(-300, -300, "R5");
    idle(2);
    send(0, 0, "R5");
    send(-600, 0, "R5");

    // R6: irregular spacing
    for (int k = 0; k < 10; k++) begin
      send(100 * k - 400, 37 * k - 150, "R6");
      idle(k % 4);
    end

    idle(LAT + 10);
    check(sb.size() == 0, "R6", "results still pending", sb.size(), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule